// File: doc/BRIEF.md
# Converter Conversion Sequencer with Result Formatting

This block controls an external successive-approximation converter. Software programs it through one 8-bit control word. The word turns the block on, chooses one-shot or repeated conversion, picks the conversion clock source, and selects the result encoding. Writing the start/busy bit sends a one-cycle start pulse to the converter. The block then waits for the converter's done pulse. It keeps the start/busy bit high for the whole conversion and then clears it or fires a new conversion, as the mode bits dictate.

Each completed conversion returns 13 raw bits: a sign bit and 12 magnitude bits. The block keeps the newest two raw samples. It presents both samples as 16-bit words in one of six encodings, chosen by the single-ended/differential bit and the two format bits. The current format setting applies to both words at all times. Changing the format therefore re-encodes both results at once.

The conversion clock is a clock enable given to the converter. It comes either from a dedicated oscillator tick input or from the system clock divided by a programmable value.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the control word reads 0x00, both result words are 0 and neither a start pulse nor a conversion tick is issued.
- R2: The control word fields are: enable at bit 7, repeat at bit 6, clock source at bit 5, format at bits 4:3, input mode at bit 2 and start/busy at bit 0. A write stores all fields. Bit 1 always reads 0.
- R3: A write that sets the enable bit to 0 leaves the start/busy bit at 0 and produces no start pulse, even if that write sets start/busy to 1.
- R4: A write with enable=1 and start/busy=1 makes start/busy read 1 from the next cycle and produces exactly one start pulse one cycle wide. With repeat=0, start/busy returns to 0 in the cycle the result is stored.
- R5: With repeat=1 and stop-on-threshold=1, a new conversion starts after each completion until a completion occurs while the threshold flag is 1. At that completion start/busy clears and no further start pulse follows.
- R6: With repeat=1, a software write of start/busy=0 ends retriggering for any value of stop-on-threshold. A conversion already in flight still completes and is stored. With stop-on-threshold=0, the threshold flag has no effect.
- R7: With the clock-source bit at 1, the conversion tick follows the oscillator tick input. With it at 0, the tick fires once every (divider+1) system clocks. With enable=0 no tick is issued.
- R8: In single-ended mode (bit 2 = 0), format bit 3 = 1 gives {4'b0, mag}, and format bit 3 = 0 gives {mag, 4'b0}. Format bit 4 and the raw sign bit are ignored.
- R9: In differential mode, format 11 gives {sign, 3'b0, mag} and format 10 gives {sign, mag, 3'b0}.
- R10: In differential mode, format 01 gives the signed value (negative magnitude when sign=1) as 16-bit two's complement. Format 00 gives that value's low 13 bits followed by 3'b0.
- R11: When a result is stored, the previous-result word takes the older sample in the same cycle that the current-result word takes the new one. Both words are always encoded with the current format setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word write value |
| rd_ctrl | output | 8 | Control word read value |
| sys_div | input | DIV_W | System clock divider value (tick every sys_div+1 clocks) |
| osc_tick | input | 1 | Tick from the dedicated oscillator, already in the clk domain |
| conv_tick | output | 1 | Conversion clock enable to the converter |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | RAW_W+1 | Raw sample: sign at the top bit, magnitude below |
| stop_on_thr | input | 1 | Stop repeated conversion when the threshold flag is set |
| thr_flag | input | 1 | Threshold flag from outside logic |
| result_cur | output | RES_W | Newest result, formatted |
| result_prev | output | RES_W | Preceding result, formatted |

## Verification
The formatter is tried with random raw samples under random input mode and format settings. This separates the six encodings from each other and shows that ignored bits stay ignored. Directed samples with sign=1 and magnitude 0 or 4095 separate two's complement from sign-magnitude at their extremes. Repeated-conversion runs use three settings: the threshold flag raised with stop-on-threshold set, the flag raised with stop-on-threshold clear, and a software stop during a conversion. These separate a hardware stop from a software stop, and show that an in-flight conversion still finishes. Tick counting over fixed windows, for each clock source and with the block disabled, tells the oscillator path from the divided path.

// File: rtl/adc_seq_pkg.sv
// Package: shared control word type for the conversion sequencer.
// Assumes the bit positions below are the software-visible layout.
package adc_seq_pkg;

    // Control word, MSB first; bit positions are software visible.
    typedef struct packed {
        logic       en;     // bit 7: block enable
        logic       rpt;    // bit 6: repeat conversions
        logic       csel;   // bit 5: 1 = oscillator tick, 0 = divided clock
        logic [1:0] fmt;    // bits 4:3: result encoding
        logic       diff;   // bit 2: 1 = differential input
        logic       rsv;    // bit 1: always zero
        logic       go;     // bit 0: start/busy
    } ctrl_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_START = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/adc_ctrl_reg.sv
// Module: control word register.
// Holds all fields. Software writes win over hardware updates in the same
// cycle. Hardware clears start/busy on a completion when repeat is off, or
// when the threshold stop applies. The go bit can only be set while enable
// is being written as 1.
module adc_ctrl_reg
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       done_evt,
    input  logic       stop_on_thr,
    input  logic       thr_flag,
    output ctrl_t      ctrl
);

    ctrl_t wr_word;
    logic  hw_stop;

    // Shape the written word: reserved bit forced low, go gated by enable.
    always_comb begin
        wr_word      = ctrl_t'(wr_data);
        wr_word.rsv  = 1'b0;
        wr_word.go   = wr_data[0] & wr_data[7];
    end

    // Decide whether a completion ends the start/busy state.
    always_comb begin
        hw_stop = !ctrl.rpt || (stop_on_thr && thr_flag);
    end

    // Register update: software write first, then hardware clear on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl <= wr_word;
        end else if (done_evt && ctrl.go && hw_stop) begin
            ctrl.go <= 1'b0;
        end
    end

    // R3
    go_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.go && !ctrl.en));

    // R4
    single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && !ctrl.rpt && !wr_en) |=> !ctrl.go);

    // R5
    thr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && ctrl.rpt && stop_on_thr && thr_flag && !wr_en) |=> !ctrl.go);

    // R2
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.rsv);

endmodule

// File: rtl/adc_clk_sel.sv
// Module: conversion clock enable source.
// Chooses between the oscillator tick (assumed already synchronous to clk)
// and a divider that fires once every div+1 clocks. Nothing is issued while
// the block is disabled.
module adc_clk_sel #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             csel,
    input  logic [DIV_W-1:0] div,
    input  logic             osc_tick,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic             div_tick;

    // Divider terminal count; >= also recovers when div shrinks.
    always_comb begin
        div_tick = (cnt >= div);
    end

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (div_tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Select the tick source and gate it with enable.
    always_comb begin
        tick = en && (csel ? osc_tick : div_tick);
    end

    // R7
    tick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> en);

endmodule

// File: rtl/adc_seq_fsm.sv
// Module: start/complete handshake sequencer.
// Issues a one-cycle start pulse whenever start/busy is set while idle, then
// waits for the converter's done pulse. Done pulses outside the wait state
// are ignored. An in-flight conversion always runs to completion.
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic go,
    input  logic conv_done,
    output logic conv_start,
    output logic done_evt
);

    seq_state_t state, state_nx;

    // Next-state logic of the handshake.
    always_comb begin
        state_nx = state;
        case (state)
            SQ_IDLE:  if (go && en) state_nx = SQ_START;
            SQ_START: state_nx = SQ_WAIT;
            SQ_WAIT:  if (conv_done) state_nx = SQ_IDLE;
            default:  state_nx = SQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Decode the outputs from the state register.
    always_comb begin
        conv_start = (state == SQ_START);
        done_evt   = (state == SQ_WAIT) && conv_done;
    end

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R3
    start_needs_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_start) |-> $past(go && en));

endmodule

// File: rtl/adc_result_fmt.sv
// Module: raw sample to 16-bit result word encoder (combinational).
// Raw input is {sign, magnitude}. Needs RES_W >= RAW_W + 2 so that every
// encoding has a zero-fill field.
module adc_result_fmt #(
    parameter int RAW_W = 12,
    parameter int RES_W = 16
) (
    input  logic [RAW_W:0]   raw,
    input  logic             diff,
    input  logic [1:0]       fmt,
    output logic [RES_W-1:0] res
);

    localparam int PAD = RES_W - RAW_W;

    logic [RAW_W-1:0] mag;
    logic             sgn;
    logic [RES_W-1:0] mag_w;
    logic [RES_W-1:0] signed_w;

    // Split the raw sample and build the signed value.
    always_comb begin
        mag      = raw[RAW_W-1:0];
        sgn      = raw[RAW_W];
        mag_w    = {{PAD{1'b0}}, mag};
        signed_w = sgn ? (~mag_w + 1'b1) : mag_w;
    end

    // Pick the encoding from input mode and format bits.
    always_comb begin
        if (!diff) begin
            res = fmt[0] ? mag_w : {mag, {PAD{1'b0}}};
        end else begin
            case (fmt)
                2'b11:   res = {sgn, {(PAD-1){1'b0}}, mag};
                2'b10:   res = {sgn, mag, {(PAD-1){1'b0}}};
                2'b01:   res = signed_w;
                default: res = {signed_w[RAW_W:0], {(PAD-1){1'b0}}};
            endcase
        end
    end

endmodule

// File: rtl/adc_seq_top.sv
// Module: converter sequencer top level.
// Ties together the control word, the clock source, the handshake sequencer
// and two result encoders. It keeps the newest two raw samples and encodes
// both with the current format setting. Assumes the converter returns a
// single-cycle done pulse with conv_data valid in that cycle.
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int RAW_W = 12,
    parameter int RES_W = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_ctrl,
    input  logic [DIV_W-1:0] sys_div,
    input  logic             osc_tick,
    output logic             conv_tick,
    output logic             conv_start,
    input  logic             conv_done,
    input  logic [RAW_W:0]   conv_data,
    input  logic             stop_on_thr,
    input  logic             thr_flag,
    output logic [RES_W-1:0] result_cur,
    output logic [RES_W-1:0] result_prev
);

    localparam int N_RES = 2;

    ctrl_t          ctrl;
    logic           done_evt;
    logic [RAW_W:0] raw_hold [N_RES];
    logic [RES_W-1:0] res_w  [N_RES];

    adc_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .done_evt    (done_evt),
        .stop_on_thr (stop_on_thr),
        .thr_flag    (thr_flag),
        .ctrl        (ctrl)
    );

    adc_clk_sel #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl.en),
        .csel     (ctrl.csel),
        .div      (sys_div),
        .osc_tick (osc_tick),
        .tick     (conv_tick)
    );

    adc_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (ctrl.en),
        .go         (ctrl.go),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .done_evt   (done_evt)
    );

    // Sample history: index 0 newest, index 1 the one before it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_hold[0] <= '0;
            raw_hold[1] <= '0;
        end else if (done_evt) begin
            raw_hold[0] <= conv_data;
            raw_hold[1] <= raw_hold[0];
        end
    end

    // One encoder per held sample, all sharing the current format.
    for (genvar gi = 0; gi < N_RES; gi++) begin : g_fmt
        adc_result_fmt #(.RAW_W(RAW_W), .RES_W(RES_W)) u_fmt (
            .raw  (raw_hold[gi]),
            .diff (ctrl.diff),
            .fmt  (ctrl.fmt),
            .res  (res_w[gi])
        );
    end

    // Drive the read-back and result ports.
    always_comb begin
        rd_ctrl     = ctrl;
        result_cur  = res_w[0];
        result_prev = res_w[1];
    end

    // R11
    prev_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> (raw_hold[1] == $past(raw_hold[0])));

    // R11
    cur_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> (raw_hold[0] == $past(conv_data)));

endmodule

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;

    localparam int RAW_W = 12;
    localparam int RES_W = 16;
    localparam int DIV_W = 8;
    localparam int LAT   = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = '0;
    logic [7:0]       rd_ctrl;
    logic [DIV_W-1:0] sys_div = '0;
    logic             osc_tick = 1'b0;
    logic             conv_tick;
    logic             conv_start;
    logic             conv_done = 1'b0;
    logic [RAW_W:0]   conv_data = '0;
    logic             stop_on_thr = 1'b0;
    logic             thr_flag = 1'b0;
    logic [RES_W-1:0] result_cur;
    logic [RES_W-1:0] result_prev;

    int checks = 0;
    int fails  = 0;
    int start_cnt = 0;
    int done_cnt  = 0;
    logic [RAW_W:0] hist_cur = '0;
    logic [RAW_W:0] hist_prev = '0;
    logic           force_en = 1'b0;
    logic [RAW_W:0] force_val = '0;

    always #2 clk = ~clk;

    adc_seq_top #(.RAW_W(RAW_W), .RES_W(RES_W), .DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_ctrl(rd_ctrl), .sys_div(sys_div), .osc_tick(osc_tick),
        .conv_tick(conv_tick), .conv_start(conv_start), .conv_done(conv_done),
        .conv_data(conv_data), .stop_on_thr(stop_on_thr), .thr_flag(thr_flag),
        .result_cur(result_cur), .result_prev(result_prev)
    );

    // Converter stub: LAT ticks after a start, one-cycle done pulse.
    initial begin
        automatic bit busy = 0;
        automatic int cnt = 0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (rst_n && conv_start) begin
                start_cnt++;
                busy = 1;
                cnt = 0;
                conv_data = force_en ? force_val : RAW_W'($urandom) | ((RAW_W+1)'($urandom % 2) << RAW_W);
            end else if (rst_n && busy && conv_tick) begin
                if (cnt == LAT - 1) begin
                    conv_done = 1'b1;
                    busy = 0;
                    done_cnt++;
                    hist_prev = hist_cur;
                    hist_cur  = conv_data;
                end else begin
                    cnt++;
                end
            end
        end
    end

    function automatic logic [15:0] exp_fmt(input logic [12:0] r, input logic diff, input logic [1:0] fm);
        logic [11:0] m;
        logic [15:0] v;
        m = r[11:0];
        v = r[12] ? 16'(-int'(m)) : {4'h0, m};
        if (!diff) return fm[0] ? {4'h0, m} : {m, 4'h0};
        case (fm)
            2'b11:   return {r[12], 3'b000, m};
            2'b10:   return {r[12], m, 3'b000};
            2'b01:   return v;
            default: return {v[12:0], 3'b000};
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick_wait(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500 && rd_ctrl[0]; i++) tick_wait(1);
    endtask

    task automatic wait_dones(input int target);
        for (int i = 0; i < 2000 && done_cnt < target; i++) tick_wait(1);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int s0;
        int n;
        logic [1:0] fm;
        logic dif;
        void'($urandom(32'd7));
        tick_wait(4);
        rst_n = 1'b1;
        tick_wait(1);
        // R1 reset state
        check("R1 ctrl", rd_ctrl, 8'h00);
        check("R1 cur", result_cur, 16'h0);
        check("R1 prev", result_prev, 16'h0);
        check("R1 start", conv_start, 1'b0);
        check("R1 tick", conv_tick, 1'b0);

        // R2 field storage, bit 1 reads zero
        wr(8'hFE);
        check("R2 readback", rd_ctrl, 8'hFC);
        wr(8'h5E);
        check("R2 readback2", rd_ctrl, 8'h5C);

        // R3 go ignored while disabled
        s0 = start_cnt;
        wr(8'h01);
        check("R3 go stays 0", rd_ctrl, 8'h00);
        wr(8'h7F);
        check("R3 go stays 0 all set", rd_ctrl, 8'h7C);
        tick_wait(20);
        check("R3 no start", start_cnt, s0);
        check("R7 no tick when off", conv_tick, 1'b0);

        // R4 single conversion
        sys_div = 8'd0;
        s0 = start_cnt;
        wr(8'h80 | 8'h08 | 8'h01);
        check("R4 busy reads 1", rd_ctrl[0], 1'b1);
        wait_idle();
        check("R4 busy clears", rd_ctrl[0], 1'b0);
        check("R4 one start", start_cnt, s0 + 1);
        tick_wait(10);
        check("R4 no retrigger", start_cnt, s0 + 1);
        check("R8 cur after single", result_cur, exp_fmt(hist_cur, 1'b0, 2'b01));

        // R8 R9 R10 R11 random formats
        for (int k = 0; k < 24; k++) begin
            fm  = 2'($urandom);
            dif = 1'($urandom);
            wr({3'b100, fm, dif, 2'b01});
            wait_idle();
            check(dif ? (fm[1] ? "R9 cur" : "R10 cur") : "R8 cur", result_cur, exp_fmt(hist_cur, dif, fm));
            check("R11 prev", result_prev, exp_fmt(hist_prev, dif, fm));
        end

        // R11 reformat both without a conversion
        for (int f = 0; f < 8; f++) begin
            wr({3'b100, 2'(f), 1'(f >> 2), 2'b00});
            check("R11 cur reformat", result_cur, exp_fmt(hist_cur, 1'(f >> 2), 2'(f)));
            check("R11 prev reformat", result_prev, exp_fmt(hist_prev, 1'(f >> 2), 2'(f)));
        end

        // R10 R9 directed extremes
        force_en = 1'b1;
        force_val = 13'h1000;
        wr(8'h80 | 8'h04 | 8'h01);
        wait_idle();
        check("R10 neg zero left", result_cur, 16'h0000);
        force_val = 13'h1FFF;
        wr(8'h80 | 8'h08 | 8'h04 | 8'h01);
        wait_idle();
        check("R10 min right", result_cur, 16'hF001);
        check("R10 neg zero prev right", result_prev, 16'h0000);
        wr(8'h80 | 8'h18 | 8'h04);
        check("R9 max right", result_cur, 16'h8FFF);
        check("R9 neg zero prev", result_prev, 16'h8000);
        wr(8'h80 | 8'h10);
        check("R8 sign ignored", result_cur, 16'hFFF0);
        force_en = 1'b0;

        // R5 repeat with threshold stop
        stop_on_thr = 1'b1;
        thr_flag = 1'b0;
        n = done_cnt;
        wr(8'hC0 | 8'h08 | 8'h01);
        wait_dones(n + 3);
        check("R5 still busy", rd_ctrl[0], 1'b1);
        check("R5 retriggered", (done_cnt >= n + 3), 1'b1);
        thr_flag = 1'b1;
        wait_idle();
        tick_wait(30);
        check("R5 stopped", rd_ctrl[0], 1'b0);
        check("R5 no extra start", start_cnt, done_cnt);
        s0 = start_cnt;
        tick_wait(30);
        check("R5 starts stable", start_cnt, s0);

        // R6 software stop, threshold ignored without stop-on-threshold
        stop_on_thr = 1'b0;
        thr_flag = 1'b1;
        n = done_cnt;
        wr(8'hC0 | 8'h18 | 8'h04 | 8'h01);
        wait_dones(n + 3);
        check("R6 flag ignored", rd_ctrl[0], 1'b1);
        wr(8'hC0 | 8'h18 | 8'h04);
        check("R6 busy cleared", rd_ctrl[0], 1'b0);
        tick_wait(30);
        check("R6 in-flight done", done_cnt, start_cnt);
        check("R6 stored", result_cur, exp_fmt(hist_cur, 1'b1, 2'b11));
        s0 = start_cnt;
        tick_wait(30);
        check("R6 no restart", start_cnt, s0);
        thr_flag = 1'b0;

        // R7 oscillator source
        wr(8'hA0);
        fork
            begin
                for (int i = 0; i < 40; i++) begin
                    @(negedge clk);
                    osc_tick = 1'($urandom % 3 == 0);
                end
                osc_tick = 1'b0;
            end
            begin
                for (int i = 0; i < 39; i++) begin
                    @(negedge clk);
                    #1;
                    check("R7 osc follow", conv_tick, osc_tick);
                end
            end
        join

        // R7 divided source: 40 cycles at divider 3 give 10 ticks
        sys_div = 8'd3;
        wr(8'h80);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            tick_wait(1);
            n += int'(conv_tick);
        end
        check("R7 div count", n, 10);
        wr(8'h00);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            tick_wait(1);
            n += int'(conv_tick);
        end
        check("R7 disabled", n, 0);

        finish_run();
    end

endmodule